// File: doc/BRIEF.md
# Non-secure FPU access gating unit

This block keeps three control registers that govern floating-point access and decides, for each floating-point instruction, whether it runs or traps. A guard register lets secure software deny the FPU to the non-secure world. The second register grants coprocessor access per privilege level. The third holds hypervisor trap bits. When the guard denies access, selected control bits in the other two registers show fixed values on read and keep their stored value on write. The stored bits themselves are never changed by this forcing.

"Gated" means all four of the following hold: EL3 is implemented, EL3 runs 32-bit, the current state is non-secure, and bit 10 of the guard register is 0. Software reaches the registers through one select/write/read port. The execution pipe raises `fp_req` with the current exception level and gets back a registered trap decision.

Top module: `fpu_access_gate`

## Requirements
- R1: After a synchronous reset, all three registers hold zero, and `rd_data`, `trap_valid` and `trap_el` are zero. The select encoding is 0 = guard, 1 = coprocessor access, 2 = hypervisor trap. Select 3 reads zero and ignores writes.
- R2: A read of the coprocessor access register while gated returns bits [23:20] as zero. All other bits are returned as stored.
- R3: A write to the coprocessor access register while gated leaves bits [23:20] at their stored value and updates every other bit.
- R4: A read of the hypervisor trap register while gated returns bits [11:10] as one. All other bits are returned as stored.
- R5: A write to the hypervisor trap register while gated keeps bits [11:10] at their stored value and updates every other bit.
- R6: An FP request at EL0, EL1 or EL2 while gated raises a trap. `trap_el` is 2 when the request came from EL2 and 1 otherwise. This check takes priority over every other trap check.
- R7: When EL3 is absent or 64-bit, or the state is secure, the guard register has no effect: reads return stored values and writes update all bits.
- R8: Forcing acts only on read data. When guard bit 10 is later set, the values written before the forcing are visible again.
- R9: When not gated, FP requests are checked as follows, in this order:
  - At EL0, a trap to EL1 unless coprocessor bits [21:20] are 2'b11.
  - At EL1, a trap to EL1 if coprocessor bit 20 is 0.
  - At EL0..2 in non-secure state, a trap to EL2 if hypervisor bit 10 is 1.
  - Otherwise, and always at EL3, there is no trap.
- R10: `rd_data` is valid one cycle after `rd_en`, and the trap outputs are valid one cycle after `fp_req`. Without `fp_req`, `trap_valid` is 0 and `trap_el` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select (0 guard, 1 coprocessor access, 2 hypervisor trap) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| el3_present | input | 1 | EL3 is implemented |
| el3_is_64 | input | 1 | EL3 runs in 64-bit state |
| nonsecure | input | 1 | Current state is non-secure |
| cur_el | input | 2 | Current exception level |
| fp_req | input | 1 | An FP instruction asks to execute |
| trap_valid | output | 1 | Registered: the FP request traps |
| trap_el | output | 2 | Registered target level of the trap |

## Verification
Directed sequences write all-ones patterns from secure state and then read them back gated, then ungated, then with guard bit 10 set. This separates read-side forcing from write-side holding, and shows that stored bits survive. Writes of zero made while gated are read back from secure state, so a write that leaks into the protected field shows up. Random cycles vary EL3 presence and width, security state and level against a bench model. FP requests at each level tell the gating trap apart from the three normal checks and confirm its priority.

// File: rtl/fag_pkg.sv
package fag_pkg;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = 2;
  localparam int EL_W    = 2;
  localparam int GUARD_BIT = 10;
  localparam int CP_LO   = 20;
  localparam int CP_W    = 4;
  localparam int HT_LO   = 10;
  localparam int HT_W    = 2;
  localparam logic [DATA_W-1:0] CP_MASK = DATA_W'(((1 << CP_W) - 1) << CP_LO);
  localparam logic [DATA_W-1:0] HT_MASK = DATA_W'(((1 << HT_W) - 1) << HT_LO);

  typedef enum logic [SEL_W-1:0] {
    SEL_GUARD = 2'd0,
    SEL_CPAC  = 2'd1,
    SEL_HTRAP = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fag_regfile.sv
module fag_regfile
  import fag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              gated,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] guard_q,
  output logic [DATA_W-1:0] cpac_q,
  output logic [DATA_W-1:0] htrap_q
);
  logic [DATA_W-1:0] cpac_d, htrap_d;

  always_comb begin
    cpac_d  = gated ? ((wr_data & ~CP_MASK) | (cpac_q & CP_MASK)) : wr_data;
    htrap_d = gated ? ((wr_data & ~HT_MASK) | (htrap_q & HT_MASK)) : wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      guard_q <= '0;
      cpac_q  <= '0;
      htrap_q <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(reg_sel))
        SEL_GUARD: guard_q <= wr_data;
        SEL_CPAC:  cpac_q  <= cpac_d;
        SEL_HTRAP: htrap_q <= htrap_d;
        default: ;
      endcase
    end
  end

  AST_CPAC_FIELD_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == SEL_CPAC && gated) |=> $stable(cpac_q[CP_LO +: CP_W])); // R3
  AST_HTRAP_FIELD_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == SEL_HTRAP && gated) |=> $stable(htrap_q[HT_LO +: HT_W])); // R5
endmodule

// File: rtl/fag_read_view.sv
module fag_read_view
  import fag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              gated,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] guard_q,
  input  logic [DATA_W-1:0] cpac_q,
  input  logic [DATA_W-1:0] htrap_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] view;

  always_comb begin
    case (reg_sel_e'(reg_sel))
      SEL_GUARD: view = guard_q;
      SEL_CPAC:  view = gated ? (cpac_q & ~CP_MASK) : cpac_q;
      SEL_HTRAP: view = gated ? (htrap_q | HT_MASK) : htrap_q;
      default:   view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= view;
  end

  AST_READ_CP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == SEL_CPAC && gated) |=> (rd_data[CP_LO +: CP_W] == '0)); // R2
  AST_READ_HT_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == SEL_HTRAP && gated) |=> (rd_data[HT_LO +: HT_W] == '1)); // R4
endmodule

// File: rtl/fag_trap_eval.sv
module fag_trap_eval
  import fag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              gated,
  input  logic              nonsecure,
  input  logic [EL_W-1:0]   cur_el,
  input  logic              fp_req,
  input  logic [DATA_W-1:0] cpac_q,
  input  logic [DATA_W-1:0] htrap_q,
  output logic              trap_valid,
  output logic [EL_W-1:0]   trap_el
);
  logic            low_el, t_v;
  logic [EL_W-1:0] t_el;

  always_comb begin
    low_el = (cur_el <= EL_W'(2));
    t_v  = 1'b0;
    t_el = '0;
    if (fp_req && low_el) begin
      if (gated) begin
        t_v  = 1'b1;
        t_el = (cur_el == EL_W'(2)) ? EL_W'(2) : EL_W'(1);
      end else if (cur_el == EL_W'(0) && cpac_q[CP_LO +: 2] != 2'b11) begin
        t_v  = 1'b1;
        t_el = EL_W'(1);
      end else if (cur_el == EL_W'(1) && !cpac_q[CP_LO]) begin
        t_v  = 1'b1;
        t_el = EL_W'(1);
      end else if (nonsecure && htrap_q[HT_LO]) begin
        t_v  = 1'b1;
        t_el = EL_W'(2);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid <= 1'b0;
      trap_el    <= '0;
    end else begin
      trap_valid <= t_v;
      trap_el    <= t_el;
    end
  end

  AST_GATE_TRAP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (fp_req && gated && low_el) |=> (trap_valid &&
      trap_el == (($past(cur_el) == EL_W'(2)) ? EL_W'(2) : EL_W'(1)))); // R6
  AST_NO_REQ_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    !fp_req |=> (!trap_valid && trap_el == '0)); // R10
  AST_TRAP_EL_RANGE: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> (trap_el == EL_W'(1) || trap_el == EL_W'(2))); // R9
endmodule

// File: rtl/fpu_access_gate.sv
module fpu_access_gate
  import fag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              el3_present,
  input  logic              el3_is_64,
  input  logic              nonsecure,
  input  logic [EL_W-1:0]   cur_el,
  input  logic              fp_req,
  output logic              trap_valid,
  output logic [EL_W-1:0]   trap_el
);
  logic [DATA_W-1:0] guard_q, cpac_q, htrap_q;
  logic gated;

  assign gated = el3_present && !el3_is_64 && nonsecure && !guard_q[GUARD_BIT];

  fag_regfile u_regs (
    .clk(clk), .rst(rst), .gated(gated), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .guard_q(guard_q), .cpac_q(cpac_q), .htrap_q(htrap_q)
  );

  fag_read_view u_view (
    .clk(clk), .rst(rst), .gated(gated), .reg_sel(reg_sel), .rd_en(rd_en),
    .guard_q(guard_q), .cpac_q(cpac_q), .htrap_q(htrap_q), .rd_data(rd_data)
  );

  fag_trap_eval u_trap (
    .clk(clk), .rst(rst), .gated(gated), .nonsecure(nonsecure), .cur_el(cur_el),
    .fp_req(fp_req), .cpac_q(cpac_q), .htrap_q(htrap_q),
    .trap_valid(trap_valid), .trap_el(trap_el)
  );

  AST_UNGATED_CPAC_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == SEL_CPAC && !gated) |=> (cpac_q == $past(wr_data))); // R7
endmodule

// File: tb/fpu_access_gate_test.sv
module fpu_access_gate_test;
  logic        clk = 0;
  logic        rst;
  logic [1:0]  reg_sel;
  logic        wr_en, rd_en, el3_present, el3_is_64, nonsecure, fp_req;
  logic [31:0] wr_data, rd_data;
  logic [1:0]  cur_el, trap_el;
  logic        trap_valid;

  int checks = 0, errors = 0;
  logic [31:0] m_guard = 0, m_cpac = 0, m_ht = 0;

  always #10 clk = ~clk;

  fpu_access_gate uut (.*);

  function automatic logic gate_f(logic ep, logic e64, logic ns);
    return ep && !e64 && ns && !m_guard[10];
  endfunction

  function automatic logic [31:0] view_f(logic [1:0] sel, logic g);
    case (sel)
      2'd0: return m_guard;
      2'd1: return g ? (m_cpac & ~32'h00F0_0000) : m_cpac;
      2'd2: return g ? (m_ht | 32'h0000_0C00) : m_ht;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [2:0] trap_f(logic fp, logic g, logic ns, logic [1:0] el);
    if (!fp || el == 2'd3) return 3'b000;
    if (g) return {1'b1, (el == 2'd2) ? 2'd2 : 2'd1};
    if (el == 2'd0 && m_cpac[21:20] != 2'b11) return 3'b101;
    if (el == 2'd1 && !m_cpac[20]) return 3'b101;
    if (ns && m_ht[10]) return 3'b110;
    return 3'b000;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [31:0] last_rd;
  // one cycle: drive at negedge, check at following negedge
  task automatic cyc(string tag, logic [1:0] sel, logic we, logic [31:0] wd, logic re,
                     logic fp, logic ep, logic e64, logic ns, logic [1:0] el);
    logic g;
    logic [31:0] exp_rd;
    logic [2:0]  exp_t;
    reg_sel = sel; wr_en = we; wr_data = wd; rd_en = re; fp_req = fp;
    el3_present = ep; el3_is_64 = e64; nonsecure = ns; cur_el = el;
    g = gate_f(ep, e64, ns);
    exp_rd = re ? view_f(sel, g) : last_rd;
    exp_t  = trap_f(fp, g, ns, el);
    if (we) begin
      case (sel)
        2'd0: m_guard = wd;
        2'd1: m_cpac = g ? ((wd & ~32'h00F0_0000) | (m_cpac & 32'h00F0_0000)) : wd;
        2'd2: m_ht = g ? ((wd & ~32'h0000_0C00) | (m_ht & 32'h0000_0C00)) : wd;
        default: ;
      endcase
    end
    @(posedge clk); @(negedge clk);
    last_rd = exp_rd;
    check({tag, " rd_data"}, rd_data, exp_rd);
    check({tag, " trap"}, {29'd0, trap_valid, trap_el}, {29'd0, exp_t});
  endtask

  initial begin
    int unsigned seed = 32'd2024;
    void'($urandom(seed));
    reg_sel = 0; wr_en = 0; wr_data = 0; rd_en = 0; fp_req = 0;
    el3_present = 0; el3_is_64 = 0; nonsecure = 0; cur_el = 0;
    rst = 1; last_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 reset rd_data", rd_data, 0);
    check("R1 reset trap", {30'd0, trap_valid, trap_el}, 0);
    cyc("R1", 2'd2, 0, 0, 1, 0, 1, 0, 0, 0);
    cyc("R1 sel3", 2'd3, 1, 32'hFFFF_FFFF, 1, 0, 1, 0, 0, 0);
    // secure writes full values
    cyc("R7 secure wr", 2'd1, 1, 32'hFFFF_FFFF, 0, 0, 1, 0, 0, 1);
    cyc("R7 secure wr", 2'd2, 1, 32'h0000_0000, 0, 0, 1, 0, 0, 2);
    cyc("R2 gated read", 2'd1, 0, 0, 1, 0, 1, 0, 1, 1);
    cyc("R4 gated read", 2'd2, 0, 0, 1, 0, 1, 0, 1, 2);
    cyc("R3 gated wr", 2'd1, 1, 32'h0000_0000, 0, 0, 1, 0, 1, 1);
    cyc("R3 secure rd", 2'd1, 0, 0, 1, 0, 1, 0, 0, 1);
    cyc("R5 gated wr", 2'd2, 1, 32'hFFFF_FFFF, 0, 0, 1, 0, 1, 2);
    cyc("R5 secure rd", 2'd2, 0, 0, 1, 0, 1, 0, 0, 2);
    cyc("R6 el0", 2'd0, 0, 0, 0, 1, 1, 0, 1, 0);
    cyc("R6 el1", 2'd0, 0, 0, 0, 1, 1, 0, 1, 1);
    cyc("R6 el2", 2'd0, 0, 0, 0, 1, 1, 0, 1, 2);
    cyc("R7 e64 rd", 2'd1, 0, 0, 1, 1, 1, 1, 1, 0);
    cyc("R7 noel3 rd", 2'd2, 0, 0, 1, 1, 0, 0, 1, 2);
    cyc("R7 noel3 wr", 2'd1, 1, 32'h0030_0000, 0, 0, 0, 0, 1, 0);
    cyc("R8 set guard", 2'd0, 1, 32'h0000_0400, 0, 0, 0, 0, 0, 3);
    cyc("R8 visible", 2'd1, 0, 0, 1, 0, 1, 0, 1, 1);
    cyc("R9 el0 ok", 2'd0, 0, 0, 0, 1, 1, 0, 1, 0);
    cyc("R9 el1 cp", 2'd1, 1, 32'h0020_0000, 0, 1, 1, 0, 1, 1);
    cyc("R9 el1 trap", 2'd0, 0, 0, 0, 1, 1, 0, 1, 1);
    cyc("R9 el0 trap", 2'd2, 1, 32'h0000_0400, 0, 1, 1, 0, 1, 0);
    cyc("R9 ht el2", 2'd0, 0, 0, 0, 1, 1, 0, 1, 2);
    cyc("R9 el3", 2'd0, 0, 0, 0, 1, 1, 0, 0, 3);
    cyc("R10 no req", 2'd0, 0, 0, 0, 0, 1, 0, 1, 2);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] wd;
      logic [1:0] sel;
      sel = 2'($urandom());
      wd = $urandom();
      if (sel == 2'd0 && ($urandom() % 2 == 0)) wd[10] = 1'b0;
      cyc("R10 random", sel, 1'($urandom()), wd, 1'($urandom()), 1'($urandom()),
          ($urandom() % 4) != 0, ($urandom() % 4) == 0, 1'($urandom()), 2'($urandom()));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule